// File: doc/BRIEF.md
# Mixed-Trigger Interrupt Aggregator

This block gathers 32 interrupt sources into a single request line for a processor. Each source position has a trigger type fixed at build time. A level position reports the synchronized state of its input. An edge position catches a rising edge in a sticky latch, and the latch holds until software clears it. Three of the positions carry summary lines from a secondary peripheral controller. Those three are plain level inputs.

A 32-bit enable mask selects which sources may interrupt. The block ANDs the status with the mask to form the pending set. The request line is the registered OR of that set. Next to the request line, the block gives the number of the lowest pending enabled source, together with a valid flag. Software uses this number to pick the handler to run.

Software reaches the block through a small register port. Reads are combinational. Writes take effect at the clock edge.

| Address | Register | Access |
|---------|----------|--------|
| 0 | Status | Read only |
| 1 | Mask | Read and write |
| 2 | Latch | Read, and write-to-clear |

Top module: `irq_hub_top`

## Requirements
- R1: After reset, the mask and latch registers read zero, `irq_req` is low and `irq_idx_vld` is low.
- R2: A level position (any bit outside the edge map 0x71CF0000) reads in the status register (address 0) as its input level, two clocks after the input changes. It returns to 0 when the input falls.
- R3: An edge position (bits 16-19, 22-24 and 28-30, edge map 0x71CF0000) sets on a rising edge of its synchronized input. It stays set in both the status and latch registers (address 2) after the input falls.
- R4: A write to the latch register clears each edge bit written as 0 and leaves each bit written as 1 unchanged. A write never sets a bit. Level positions of the latch register always read 0.
- R5: If a rising edge reaches an edge position in the same cycle as a write that clears it, the bit stays set.
- R6: `irq_req` goes high one clock after (status AND mask) becomes non-zero, and low one clock after it returns to zero.
- R7: `irq_idx` gives the lowest-numbered bit of (status AND mask), registered in the same cycle as `irq_req`. `irq_idx_vld` is high exactly when that set is non-empty.
- R8: The mask register (address 1) stores all 32 written bits. A source whose mask bit is 0 never raises `irq_req` and is never chosen as `irq_idx`.
- R9: The status register is read-only. A write to address 0 changes no register and no output.
- R10: The cascade summary positions 4, 5 and 6 behave as level inputs. A pulse on them is not held after the input falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 32 | Raw interrupt source inputs, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 mask, 2 latch, 3 reads zero |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_idx | output | 5 | Lowest pending enabled source number |
| irq_idx_vld | output | 1 | High when some enabled source is pending |

## Verification
The bench sends a rising edge into an edge position in the same cycle as a write that clears it. A design that gives priority to the clear would lose that interrupt. The bench also checks that a latch write with all bits at 1 sets nothing. A design that writes the latch instead of masking it would then raise interrupts that never happened. Several sources are made pending at once, and the bench then masks the lowest of them. An encoder that picks the highest bit, or ignores the mask, would report the wrong source number. Finally, the bench pulses the cascade summary inputs and counts the exact cycle at which the request line rises. This catches a level position that latches like an edge, or output timing that is off by one stage.

// File: rtl/irq_hub_pkg.sv
// Package: shared register selector and default trigger map for the
// interrupt aggregator. Assumes a 32-source build for the default map.
package irq_hub_pkg;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_LATCH  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // Edge-triggered positions: 16-19, 22-24, 28-30.
    localparam logic [31:0] EDGE_MAP_DEFAULT = 32'h71CF_0000;

endpackage

// File: rtl/irq_src_sync.sv
// Module: irq_src_sync
// Brings asynchronous sources into the clock domain through a chain of
// STAGES flops, and flags a rising edge of each synchronized bit.
// Assumes STAGES >= 1 and that sources hold each level for at least one clock.
module irq_src_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: one flop of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else if (g == 0) stage_q[g] <= src;
                else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    // Purpose: remember the last synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else prev_q <= stage_q[STAGES-1];
    end

    assign lvl  = stage_q[STAGES-1];
    assign rise = stage_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/irq_latch_bank.sv
// Module: irq_latch_bank
// Holds sticky latches for the edge positions selected by EDGE_MAP and
// merges them with the level positions into one status vector.
// A clear write keeps the bits written 1 and drops the bits written 0.
// A rising edge wins over a clear in the same cycle.
module irq_latch_bank #(
    parameter int          W        = 32,
    parameter logic [W-1:0] EDGE_MAP = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] rise,
    input  logic         clr_en,
    input  logic [W-1:0] clr_val,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] status
);
    logic [W-1:0] keep;

    // Purpose: the write data acts as a keep mask only while a clear is requested.
    assign keep = clr_en ? clr_val : '1;

    // Purpose: update the edge latches; level positions stay zero.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else latch_q <= ((latch_q & keep) | rise) & EDGE_MAP;
    end

    // Purpose: edge positions report their latch, level positions their input.
    assign status = (latch_q & EDGE_MAP) | (lvl & ~EDGE_MAP);

    generate
        for (genvar i = 0; i < W; i++) begin : g_chk
            if (EDGE_MAP[i]) begin : g_edge
                // R3: a set latch without a clear stays set
                p_edge_hold_r3 : assert property (@(posedge clk) disable iff (!rst_n)
                    ($past(latch_q[i]) && $past(keep[i])) |-> latch_q[i]);
                // R5: an edge always lands, even against a clear
                p_edge_wins_r5 : assert property (@(posedge clk) disable iff (!rst_n)
                    $past(rise[i]) |-> latch_q[i]);
            end
        end
    endgenerate

endmodule

// File: rtl/irq_prio_enc.sv
// Module: irq_prio_enc
// Finds the lowest set bit of a request vector. Purely combinational.
// Assumes IW is wide enough to number W positions.
module irq_prio_enc #(
    parameter int W  = 32,
    parameter int IW = 5
) (
    input  logic [W-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Purpose: scan from the top down so the lowest set bit is assigned last.
    always_comb begin
        idx = '0;
        any = |req;
        for (int i = W-1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/irq_hub_top.sv
// Module: irq_hub_top
// Top of the interrupt aggregator. It contains the mask register, the
// register read mux, the pending logic and the registered request outputs.
// Assumes a single clock domain for the register port; src_in may be asynchronous.
module irq_hub_top
    import irq_hub_pkg::*;
#(
    parameter int          NUM_SRC     = 32,
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] EDGE_MAP    = EDGE_MAP_DEFAULT,
    localparam int         IDX_W       = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic               irq_req,
    output logic [IDX_W-1:0]   irq_idx,
    output logic               irq_idx_vld
);
    logic [NUM_SRC-1:0] lvl, rise, latch_q, status, mask_q, pending;
    logic [IDX_W-1:0]   enc_idx;
    logic               enc_any;
    logic               clr_en;

    irq_src_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .src(src_in), .lvl(lvl), .rise(rise)
    );

    assign clr_en = reg_wr && (reg_addr == SEL_LATCH);

    irq_latch_bank #(.W(NUM_SRC), .EDGE_MAP(EDGE_MAP[NUM_SRC-1:0])) u_latch (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise),
        .clr_en(clr_en), .clr_val(reg_wdata),
        .latch_q(latch_q), .status(status)
    );

    // Purpose: software-writable enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else if (reg_wr && reg_addr == SEL_MASK) mask_q <= reg_wdata;
    end

    assign pending = status & mask_q;

    irq_prio_enc #(.W(NUM_SRC), .IW(IDX_W)) u_enc (
        .req(pending), .idx(enc_idx), .any(enc_any)
    );

    // Purpose: register the request line and the chosen source together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req     <= 1'b0;
            irq_idx     <= '0;
            irq_idx_vld <= 1'b0;
        end else begin
            irq_req     <= |pending;
            irq_idx     <= enc_idx;
            irq_idx_vld <= enc_any;
        end
    end

    // Purpose: combinational register read mux.
    always_comb begin
        case (reg_sel_e'(reg_addr))
            SEL_STATUS: reg_rdata = status;
            SEL_MASK:   reg_rdata = mask_q;
            SEL_LATCH:  reg_rdata = latch_q;
            default:    reg_rdata = '0;
        endcase
    end

    // R6: the request follows the pending set one clock later
    p_req_follows_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (|$past(pending)));
    // R7: the valid flag and the request line agree
    p_vld_matches_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        irq_idx_vld == irq_req);
    // R7: the encoder picks a pending bit with nothing pending below it
    p_enc_lowest_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        enc_any |-> (pending[enc_idx] &&
                     ((pending & ((NUM_SRC'(1) << enc_idx) - NUM_SRC'(1))) == '0)));
    // R8: a mask write stores the full word
    p_mask_write_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr && reg_addr == SEL_MASK) |-> mask_q == $past(reg_wdata));

endmodule

// File: tb/irq_hub_top_tb_top.sv
module irq_hub_top_tb_top;
    localparam logic [31:0] EDGE = 32'h71CF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic [4:0]  irq_idx;
    logic        irq_idx_vld;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [31:0] m_in = '0, m_mask = '0, m_latch = '0;

    always #5 clk = ~clk;

    irq_hub_top dut_i (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_idx(irq_idx), .irq_idx_vld(irq_idx_vld)
    );

    function automatic logic [31:0] exp_status();
        return (m_latch & EDGE) | (m_in & ~EDGE);
    endfunction

    function automatic int lowest(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd0;
        if (a == 2'd1) m_mask = d;
        if (a == 2'd2) m_latch = m_latch & d;
    endtask

    task automatic apply_in(input logic [31:0] v);
        @(negedge clk);
        m_latch = m_latch | (v & ~m_in & EDGE);
        m_in = v;
        src_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d, pend;
        repeat (3) @(negedge clk);
        pend = exp_status() & m_mask;
        rd(2'd0, d); chk({tag, " R2/R3 status"}, d, exp_status());
        rd(2'd1, d); chk({tag, " R8 mask"}, d, m_mask);
        rd(2'd2, d); chk({tag, " R4 latch"}, d, m_latch);
        chk({tag, " R6 irq_req"}, {31'd0, irq_req}, {31'd0, |pend});
        chk({tag, " R7 irq_idx_vld"}, {31'd0, irq_idx_vld}, {31'd0, |pend});
        if (|pend) chk({tag, " R7 irq_idx"}, {27'd0, irq_idx}, 32'(lowest(pend)));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        void'($urandom(32'd24681));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_all("R1 reset");
        chk("R1 irq_req after reset", {31'd0, irq_req}, 32'd0);

        // R2: level bit follows the input
        wr(2'd1, 32'hFFFF_FFFF);
        apply_in(32'h0000_0008); check_all("R2 level high");
        apply_in(32'h0); check_all("R2 level low");

        // R3: edge bit held after the pulse
        apply_in(32'h0002_0000); apply_in(32'h0); check_all("R3 edge held");

        // R4: writing ones sets nothing, writing zero clears
        wr(2'd2, 32'hFFFF_FFFF); check_all("R4 all-ones write");
        wr(2'd2, ~32'h0002_0000); check_all("R4 clear bit17");
        apply_in(32'h0000_0100); wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, d); chk("R4 level position of latch reads 0", d, 32'h0);
        apply_in(32'h0);

        // R5: an edge that coincides with a clear wins
        apply_in(32'h0001_0000); apply_in(32'h0);
        @(negedge clk); src_in = 32'h0001_0000;
        @(posedge clk); @(posedge clk);
        @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = ~32'h0001_0000;
        @(posedge clk);
        @(negedge clk); reg_wr = 1'b0; reg_addr = 2'd0;
        m_in = 32'h0001_0000;
        check_all("R5 edge vs clear");
        wr(2'd2, ~32'h0001_0000); check_all("R5 later clear");
        apply_in(32'h0);

        // R6: exact request latency
        wr(2'd1, 32'h0000_0008);
        @(negedge clk); src_in = 32'h0000_0008; m_in = 32'h0000_0008;
        @(negedge clk); @(negedge clk);
        chk("R6 irq_req low two clocks after input", {31'd0, irq_req}, 32'd0);
        @(negedge clk);
        chk("R6 irq_req high three clocks after input", {31'd0, irq_req}, 32'd1);
        apply_in(32'h0);

        // R7: lowest pending wins, masking moves the choice
        wr(2'd1, 32'hFFFF_FFFF);
        apply_in(32'h0010_0204); check_all("R7 three pending");
        wr(2'd1, 32'hFFFF_FFFB); check_all("R7 lowest masked");

        // R8: mask zero blocks everything
        wr(2'd1, 32'h0); check_all("R8 all masked");
        chk("R8 irq_req blocked", {31'd0, irq_req}, 32'd0);

        // R9: write to status is ignored
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd0, 32'h0); check_all("R9 status read-only");
        wr(2'd2, 32'h0); apply_in(32'h0); check_all("R9 cleanup");

        // R10: cascade summary bits are level
        wr(2'd1, 32'h0000_0070);
        apply_in(32'h0000_0020); check_all("R10 summary high");
        chk("R10 idx 5", {27'd0, irq_idx}, 32'd5);
        apply_in(32'h0000_0070); check_all("R10 all summaries");
        apply_in(32'h0); check_all("R10 summary not held");

        // Random mix over all requirements
        for (int it = 0; it < 300; it++) begin
            int op;
            op = int'($urandom % 3);
            if (op == 0) apply_in($urandom);
            else if (op == 1) wr(2'd1, $urandom);
            else wr(2'd2, $urandom | $urandom);
            check_all("RND R2/R3/R4/R7/R8");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule